// File: doc/BRIEF.md
# Peripheral I/O Register Space

This block is the register space that sits next to an 8-bit processor core and answers its peripheral accesses. One request port serves two address views. The short port view uses addresses 0x00 to 0x3F. The data-space view reaches the same registers at the port address plus 0x20, and it also reaches an extended region from 0x60 upward. Single-bit set, clear and test requests are served only on the low part of the port view.

The space holds three general purpose 8-bit storage registers, one status register whose flags clear when a one is written, and a parameterised number of extended storage registers. Peripherals raise status flags through a per-bit event input. The block returns read data, or a bit-test result, one clock after each request. It gives a one-cycle error pulse when it rejects a bit operation.

Top module: `ioreg_space`

## Requirements
- R1: Storage register k (k = 0..2) sits at port address 0x10+k, and the status register sits at port address 0x13. Port address N (`path_sel`=0) and data address N+0x20 (`path_sel`=1) reach the same register for both reads and writes.
- R2: The extended registers sit at data addresses 0xA0 and 0xA1 and are reached only through the data view. A port-view address of 0x40 or above reads zero and writes nothing.
- R3: Data-view addresses 0x00 to 0x1F read zero and writes to them change no register.
- R4: Bit operations (`op` 2 = set, 3 = clear, 4 = test) are accepted only on the port view at addresses 0x00 to 0x1F. Any other bit operation changes no register, returns zero, and drives `err` high for exactly the cycle after the request.
- R5: A set-bit or clear-bit on a storage register changes only the bit selected by `bit_idx`.
- R6: Writing (`op` 1) to the status register clears every flag whose write-data bit is one and leaves flags whose bit is zero. Bits 7:4 of the status register are reserved and always read zero.
- R7: A set-bit on the status register clears only the selected flag. A clear-bit on the status register has no effect.
- R8: An event bit that is high in the same cycle as a clear of the same flag leaves the flag set.
- R9: After reset every storage, extended and status bit reads zero. Every bit of a storage register can be written and read back.
- R10: For a read (`op` 0) or a test, `rdata` or `test_bit` shows the result in the cycle after the request. In any cycle after a non-read, non-test cycle, both outputs are zero.
- R11: Writes to unmapped addresses, and requests with an undefined `op` code (5 to 7), change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe, one cycle per access |
| path_sel | input | 1 | 0 = port view, 1 = data-space view |
| addr | input | 8 | Access address in the selected view |
| op | input | 3 | 0 read, 1 write, 2 set bit, 3 clear bit, 4 test bit |
| wdata | input | 8 | Write data |
| bit_idx | input | 3 | Bit index for bit operations |
| evt_in | input | 8 | Per-bit flag raise events from peripherals |
| rdata | output | 8 | Registered read data |
| test_bit | output | 1 | Registered bit-test result |
| err | output | 1 | One-cycle pulse for a rejected bit operation |

## Verification
The assertions assume that `op`, `addr`, `path_sel` and `bit_idx` are known whenever `req` is high, and that `evt_in` is known in every cycle out of reset. The bench drives every input on the falling edge from a single task. It keeps `evt_in` at zero unless an event is being tested on purpose. It reads results on the next falling edge, when the registered outputs are settled.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
   typedef enum logic [2:0] {
      OP_RD   = 3'd0,
      OP_WR   = 3'd1,
      OP_SETB = 3'd2,
      OP_CLRB = 3'd3,
      OP_TSTB = 3'd4
   } io_op_e;

   localparam int VIEW_OFFSET = 32;
   localparam int BITOP_LIMIT = 32;
   localparam int PORT_LIMIT  = 64;
   localparam int EXT_FLOOR   = 96;

   function automatic logic is_bitop(input logic [2:0] op);
      return (op == OP_SETB) || (op == OP_CLRB) || (op == OP_TSTB);
   endfunction
endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
   import ioreg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_GP   = 3,
   parameter int GP_BASE  = 16,
   parameter int STAT_ADR = 19,
   parameter int NUM_EXT  = 2,
   parameter int EXT_BASE = 160,
   localparam int NUM_TGT = NUM_GP + 1 + NUM_EXT
) (
   input  logic              path_sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_TGT-1:0] hit,
   output logic              bit_ok
);
   logic              view_ok;
   logic [ADDR_W-1:0] daddr;

   always_comb begin
      if (path_sel) begin
         view_ok = addr >= ADDR_W'(VIEW_OFFSET);
         daddr   = addr;
      end else begin
         view_ok = addr < ADDR_W'(PORT_LIMIT);
         daddr   = addr + ADDR_W'(VIEW_OFFSET);
      end
   end

   assign bit_ok = !path_sel && (addr < ADDR_W'(BITOP_LIMIT));

   for (genvar i = 0; i < NUM_GP; i++) begin : g_gp_hit
      assign hit[i] = view_ok && (daddr == ADDR_W'(GP_BASE + VIEW_OFFSET + i));
   end

   assign hit[NUM_GP] = view_ok && (daddr == ADDR_W'(STAT_ADR + VIEW_OFFSET));

   for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext_hit
      assign hit[NUM_GP+1+j] = view_ok && (daddr == ADDR_W'(EXT_BASE + j));
   end
endmodule

// File: rtl/ioreg_store.sv
module ioreg_store
   import ioreg_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] onehot;
   assign onehot = DATA_W'(1) << bit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (go) begin
         case (op)
            OP_WR:   q <= wdata;
            OP_SETB: q <= q | onehot;
            OP_CLRB: q <= q & ~onehot;
            default: q <= q;
         endcase
      end
   end
endmodule

// File: rtl/ioreg_flags.sv
module ioreg_flags
   import ioreg_pkg::*;
#(
   parameter int                  DATA_W    = 8,
   parameter logic [DATA_W-1:0]   FLAG_MASK = 8'h0F,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [DATA_W-1:0] evt_in,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] clr_mask;

   always_comb begin
      clr_mask = '0;
      if (go) begin
         case (op)
            OP_WR:   clr_mask = wdata;
            OP_SETB: clr_mask = DATA_W'(1) << bit_idx;
            default: clr_mask = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= ((q & ~clr_mask) | evt_in) & FLAG_MASK;
   end
endmodule

// File: rtl/ioreg_space.sv
module ioreg_space
   import ioreg_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 8,
   parameter int                NUM_GP    = 3,
   parameter int                GP_BASE   = 16,
   parameter int                STAT_ADR  = 19,
   parameter logic [DATA_W-1:0] FLAG_MASK = 8'h0F,
   parameter int                NUM_EXT   = 2,
   parameter int                EXT_BASE  = 160,
   localparam int IDX_W   = $clog2(DATA_W),
   localparam int NUM_TGT = NUM_GP + 1 + NUM_EXT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              path_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [DATA_W-1:0] evt_in,
   output logic [DATA_W-1:0] rdata,
   output logic              test_bit,
   output logic              err
);
   if (ADDR_W != 8) begin : g_chk_aw
      $error("ioreg_space: address width must be 8");
   end
   if (GP_BASE + NUM_GP > BITOP_LIMIT) begin : g_chk_gp
      $error("ioreg_space: storage registers must lie in the bit-operable region");
   end
   if (STAT_ADR >= BITOP_LIMIT) begin : g_chk_st
      $error("ioreg_space: status register must lie in the bit-operable region");
   end
   if (STAT_ADR >= GP_BASE && STAT_ADR < GP_BASE + NUM_GP) begin : g_chk_ov
      $error("ioreg_space: status register overlaps storage registers");
   end
   if (EXT_BASE < EXT_FLOOR || EXT_BASE + NUM_EXT > (1 << ADDR_W)) begin : g_chk_ext
      $error("ioreg_space: extended registers outside extended region");
   end

   logic [NUM_TGT-1:0] hit;
   logic               bit_ok;
   logic               bitop;
   logic               go;
   logic               reject;
   logic [DATA_W-1:0]  q   [NUM_TGT];
   logic [DATA_W-1:0]  cur;

   ioreg_decode #(
      .ADDR_W(ADDR_W), .NUM_GP(NUM_GP), .GP_BASE(GP_BASE),
      .STAT_ADR(STAT_ADR), .NUM_EXT(NUM_EXT), .EXT_BASE(EXT_BASE)
   ) u_dec (
      .path_sel(path_sel), .addr(addr), .hit(hit), .bit_ok(bit_ok)
   );

   assign bitop  = is_bitop(op);
   assign reject = req && bitop && !bit_ok;
   assign go     = req && !reject;

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_reg
      if (i == NUM_GP) begin : g_flags
         ioreg_flags #(.DATA_W(DATA_W), .FLAG_MASK(FLAG_MASK)) u_flags (
            .clk(clk), .rst_n(rst_n), .go(go && hit[i]), .op(op),
            .wdata(wdata), .bit_idx(bit_idx), .evt_in(evt_in), .q(q[i])
         );
      end else begin : g_store
         ioreg_store #(.DATA_W(DATA_W)) u_store (
            .clk(clk), .rst_n(rst_n), .go(go && hit[i]), .op(op),
            .wdata(wdata), .bit_idx(bit_idx), .q(q[i])
         );
      end
   end

   always_comb begin
      cur = '0;
      for (int k = 0; k < NUM_TGT; k++) begin
         if (hit[k]) cur = cur | q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         test_bit <= 1'b0;
         err      <= 1'b0;
      end else begin
         rdata    <= (go && op == OP_RD) ? cur : '0;
         test_bit <= go && (op == OP_TSTB) && cur[bit_idx];
         err      <= reject;
      end
   end

   logic [NUM_GP*DATA_W-1:0] gp_flat;
   for (genvar g = 0; g < NUM_GP; g++) begin : g_flat
      assign gp_flat[g*DATA_W +: DATA_W] = q[g];
   end
   logic [DATA_W-1:0] flags_view;
   assign flags_view = q[NUM_GP];
endmodule

// File: rtl/ioreg_space_chk.sv
module ioreg_space_chk
   import ioreg_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                NUM_GP    = 3,
   parameter int                STAT_ADR  = 19,
   parameter logic [DATA_W-1:0] FLAG_MASK = 8'h0F
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req,
   input logic                     path_sel,
   input logic [7:0]               addr,
   input logic [2:0]               op,
   input logic [DATA_W-1:0]        evt_in,
   input logic [DATA_W-1:0]        rdata,
   input logic                     test_bit,
   input logic                     err,
   input logic [DATA_W-1:0]        flags_view,
   input logic [NUM_GP*DATA_W-1:0] gp_flat
);
   logic rej_req;
   assign rej_req = req && is_bitop(op) && (path_sel || addr >= 8'(BITOP_LIMIT));

   logic stat_rd;
   assign stat_rd = req && op == OP_RD && !path_sel && addr == 8'(STAT_ADR);

   // R4: rejected bit operation raises err in the next cycle
   assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rej_req |=> err);
   // R4: err only follows a rejected request
   assert_err_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rej_req |=> !err);
   // R5: accepted set/clear bit changes at most one storage bit
   assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !rej_req && (op == OP_SETB || op == OP_CLRB))
      |=> ($countones(gp_flat ^ $past(gp_flat)) <= 1));
   // R6: reserved status bits read zero
   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> ((rdata & ~FLAG_MASK) == '0));
   // R6: a flag never rises without an event
   assert_no_spont_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_view & ~$past(flags_view) & ~$past(evt_in)) == '0));
   // R8: an event always leaves its flag set
   assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_view & $past(evt_in & FLAG_MASK)) == $past(evt_in & FLAG_MASK)));
   // R10: outputs idle after a cycle without read or test
   assert_idle_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && (op == OP_RD || op == OP_TSTB)) |=> (rdata == '0 && !test_bit));
endmodule

bind ioreg_space ioreg_space_chk #(
   .DATA_W(DATA_W), .NUM_GP(NUM_GP), .STAT_ADR(STAT_ADR), .FLAG_MASK(FLAG_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .path_sel(path_sel), .addr(addr),
   .op(op), .evt_in(evt_in), .rdata(rdata), .test_bit(test_bit), .err(err),
   .flags_view(flags_view), .gp_flat(gp_flat)
);

// File: tb/sim_ioreg_space.sv
`timescale 1ns/1ps
module sim_ioreg_space;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       path_sel = 1'b0;
   logic [7:0] addr = '0;
   logic [2:0] op = '0;
   logic [7:0] wdata = '0;
   logic [2:0] bit_idx = '0;
   logic [7:0] evt_in = '0;
   logic [7:0] rdata;
   logic       test_bit;
   logic       err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] r_data;
   logic       r_test;
   logic       r_err;

   always #2 clk = ~clk;

   ioreg_space u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .path_sel(path_sel), .addr(addr),
      .op(op), .wdata(wdata), .bit_idx(bit_idx), .evt_in(evt_in),
      .rdata(rdata), .test_bit(test_bit), .err(err)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic p, input logic [7:0] a, input logic [2:0] o,
                         input logic [7:0] d, input logic [2:0] b, input logic [7:0] ev);
      @(negedge clk);
      req = 1'b1; path_sel = p; addr = a; op = o; wdata = d; bit_idx = b; evt_in = ev;
      @(negedge clk);
      r_data = rdata; r_test = test_bit; r_err = err;
      req = 1'b0; evt_in = '0;
   endtask

   task automatic rd(input logic p, input logic [7:0] a);
      access(p, a, 3'd0, 8'h00, 3'd0, 8'h00);
   endtask

   task automatic wr(input logic p, input logic [7:0] a, input logic [7:0] d);
      access(p, a, 3'd1, d, 3'd0, 8'h00);
   endtask

   task automatic t_reset;
      rd(1'b0, 8'h10); chk("R9 gp0 reset", r_data, 8'h00);
      rd(1'b0, 8'h13); chk("R9 status reset", r_data, 8'h00);
      rd(1'b1, 8'hA0); chk("R9 ext reset", r_data, 8'h00);
   endtask

   task automatic t_views;
      wr(1'b0, 8'h10, 8'hA5);
      rd(1'b0, 8'h10); chk("R9 gp0 readback", r_data, 8'hA5);
      rd(1'b1, 8'h30); chk("R1 gp0 via data view", r_data, 8'hA5);
      wr(1'b1, 8'h31, 8'h3C);
      rd(1'b0, 8'h11); chk("R1 gp1 via port view", r_data, 8'h3C);
      wr(1'b0, 8'h12, 8'hFF);
      rd(1'b1, 8'h32); chk("R9 gp2 all ones", r_data, 8'hFF);
      wr(1'b0, 8'h12, 8'h00);
      rd(1'b0, 8'h12); chk("R9 gp2 all zeros", r_data, 8'h00);
   endtask

   task automatic t_ext;
      wr(1'b1, 8'hA0, 8'h5A);
      wr(1'b1, 8'hA1, 8'hC3);
      rd(1'b1, 8'hA0); chk("R2 ext0 readback", r_data, 8'h5A);
      rd(1'b0, 8'h80); chk("R2 port view above 0x3F reads zero", r_data, 8'h00);
      wr(1'b0, 8'h81, 8'h11);
      rd(1'b1, 8'hA1); chk("R2 port write above 0x3F ignored", r_data, 8'hC3);
   endtask

   task automatic t_low_data;
      wr(1'b1, 8'h10, 8'hFF);
      rd(1'b1, 8'h10); chk("R3 low data address reads zero", r_data, 8'h00);
      rd(1'b0, 8'h10); chk("R3 low data write ignored", r_data, 8'hA5);
   endtask

   task automatic t_bitops;
      access(1'b0, 8'h10, 3'd2, 8'h00, 3'd1, 8'h00);
      chk("R4 accepted bitop no err", {7'd0, r_err}, 8'h00);
      rd(1'b0, 8'h10); chk("R5 set bit1", r_data, 8'hA7);
      access(1'b0, 8'h10, 3'd3, 8'h00, 3'd7, 8'h00);
      rd(1'b0, 8'h10); chk("R5 clear bit7", r_data, 8'h27);
      access(1'b0, 8'h10, 3'd4, 8'h00, 3'd0, 8'h00);
      chk("R10 test bit0 one", {7'd0, r_test}, 8'h01);
      @(negedge clk);
      chk("R10 test result idle next cycle", {7'd0, test_bit}, 8'h00);
      access(1'b0, 8'h10, 3'd4, 8'h00, 3'd3, 8'h00);
      chk("R10 test bit3 zero", {7'd0, r_test}, 8'h00);
   endtask

   task automatic t_reject;
      access(1'b1, 8'h30, 3'd2, 8'h00, 3'd0, 8'h00);
      chk("R4 data view bitop err", {7'd0, r_err}, 8'h01);
      @(negedge clk);
      chk("R4 err one cycle", {7'd0, err}, 8'h00);
      access(1'b0, 8'h20, 3'd3, 8'h00, 3'd0, 8'h00);
      chk("R4 port 0x20 bitop err", {7'd0, r_err}, 8'h01);
      access(1'b1, 8'h30, 3'd4, 8'h00, 3'd0, 8'h00);
      chk("R4 rejected test returns zero", {7'd0, r_test}, 8'h00);
      rd(1'b0, 8'h10); chk("R4 rejected bitop no change", r_data, 8'h27);
   endtask

   task automatic t_status;
      access(1'b0, 8'h05, 3'd0, 8'h00, 3'd0, 8'hFF);
      rd(1'b0, 8'h13); chk("R6 flags raised, reserved zero", r_data, 8'h0F);
      wr(1'b0, 8'h13, 8'h05);
      rd(1'b0, 8'h13); chk("R6 write ones clears", r_data, 8'h0A);
      wr(1'b1, 8'h33, 8'h00);
      rd(1'b1, 8'h33); chk("R6 write zero keeps", r_data, 8'h0A);
      access(1'b0, 8'h13, 3'd2, 8'h00, 3'd1, 8'h00);
      rd(1'b0, 8'h13); chk("R7 set bit clears one flag", r_data, 8'h08);
      access(1'b0, 8'h13, 3'd3, 8'h00, 3'd3, 8'h00);
      rd(1'b0, 8'h13); chk("R7 clear bit no effect", r_data, 8'h08);
   endtask

   task automatic t_collide;
      access(1'b0, 8'h13, 3'd1, 8'h08, 3'd0, 8'h08);
      rd(1'b0, 8'h13); chk("R8 event wins same bit", r_data, 8'h08);
      access(1'b0, 8'h13, 3'd2, 8'h00, 3'd3, 8'h01);
      rd(1'b0, 8'h13); chk("R8 other event kept while bit3 cleared", r_data, 8'h01);
      @(negedge clk);
      chk("R10 rdata idle after read", rdata, 8'h00);
   endtask

   task automatic t_reserved;
      wr(1'b0, 8'h05, 8'hFF);
      rd(1'b0, 8'h05); chk("R11 unmapped reads zero", r_data, 8'h00);
      access(1'b0, 8'h11, 3'd5, 8'hFF, 3'd0, 8'h00);
      rd(1'b0, 8'h11); chk("R11 undefined op ignored", r_data, 8'h3C);
      rd(1'b0, 8'h10); chk("R11 gp0 untouched", r_data, 8'h27);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_views();
      t_ext();
      t_low_data();
      t_bitops();
      t_reject();
      t_status();
      t_collide();
      t_reserved();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule